// File: doc/BRIEF.md
# MAC Address Hash Filter Lookup

This block decides whether a received 48-bit destination MAC address is wanted. It takes the address through a valid/ready handshake and computes an 11-bit slot index from it. It then walks a 2048-entry table of 64-bit entries through a synchronous read port. Every entry holds a scrambled copy of a stored address and three flag bits. The walk starts at the hashed slot and moves one slot at a time, wrapping at the top of the table. It ends when an entry matches, when an empty entry turns up, or when the hop budget is used up. It then reports one result: accept, whether a stored entry matched, and that entry's skip and receive-destination flags.

The controller is a four-state machine:

- `ST_IDLE`: ready for an address. The transition on an accepted handshake latches the address and the hash, and moves to `ST_READ`.
- `ST_READ`: drives one table read and always moves to `ST_WAIT`.
- `ST_WAIT`: examines the returned entry. It has two exits:
  - On a match, an empty entry, or the last allowed hop, it moves to `ST_DONE`. This is the "finish" transition.
  - Otherwise it advances the slot index and moves back to `ST_READ`. This is the "next hop" transition.
- `ST_DONE`: presents the result for one cycle and returns to `ST_IDLE`.

Table population is done elsewhere. This block only reads the table.

Top module: `mac_hash_filter`

## Requirements
- R1: After reset, `addr_ready` is 1, and `res_valid` and `tbl_rd_en` are 0.
- R2: The hash is built as follows.
  - Split the address into `H = mac[47:32]` and `L = mac[31:0]`, then reverse the bit order inside each byte to get `H'` and `L'`.
  - The index bits 10:9 are `L'[3:2]`.
  - The index bits 8:0 are `{L'[14:8],L'[1:0]} ^ L'[23:15] ^ {H'[0],L'[31:24]}`.
  - The first table read of a lookup uses this index.
- R3: Each further read of a lookup uses the previous index plus one. Index 2047 is followed by index 0.
- R4: An entry whose valid bit (`tbl_rd_data[0]`) is 0 ends the lookup at once, with `res_hit`=0 and `res_accept`=0, and no further reads.
- R5: The table entry splits into a low word (`tbl_rd_data[31:0]`) and a high word (`tbl_rd_data[63:32]`). An entry matches when its valid bit is 1, its low word bits 31:3 equal the key, and its high word equals the key.
  - Key low word, bits 31 down to 3: `L[20]`, `L[19:16]`, `L[31:28]`, `L[27:24]`, `H[7:4]`, `H[3:0]`, `H[15:12]`, `H[11:8]`.
  - Key high word: zeros in bits 31:19, then `L[7:4]`, `L[3:0]`, `L[15:12]`, `L[11:8]`, `L[23:21]` down to bit 0.
  - Flipping any single one of these 61 compared bits prevents the match.
- R6: On a match with skip (`tbl_rd_data[1]`) equal to 0, the result has `res_accept`=1 and `res_hit`=1, and `res_dest` equals `tbl_rd_data[2]`.
- R7: On a match with skip equal to 1, the result has `res_accept`=0, `res_hit`=1 and `res_skip`=1.
- R8: A lookup makes at most `HOP_LIMIT` (12) reads.
  - If 12 valid entries in a row do not match, the result is a reject with `res_hit`=0.
  - A match at the 12th slot is still found.
- R9: Each lookup gives exactly one `res_valid` pulse, one cycle wide. `addr_ready` stays 0 from the acceptance of the address until that pulse has ended.
- R10: Read data is taken the cycle after `tbl_rd_en`. Each probe therefore costs two cycles, and `res_valid` is first seen 2n+1 cycles after the accepting edge for n reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address offered |
| addr_mac | input | 48 | Destination address, first byte in bits 47:40 |
| addr_ready | output | 1 | Block idle and able to take an address |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_idx | output | 11 | Table slot to read |
| tbl_rd_data | input | 64 | Entry returned one cycle after the request |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Address accepted |
| res_hit | output | 1 | A stored entry matched |
| res_skip | output | 1 | Skip flag of the matched entry |
| res_dest | output | 1 | Receive-destination flag of the matched entry |

## Verification
The bound checker watches a set of properties on every cycle:

- the result is a single-cycle pulse;
- the block never reads while idle;
- accept always comes with a hit and a clear skip;
- consecutive reads of one lookup step by exactly one slot;
- the read count never passes the hop limit.

Some behaviour can only be shown by the bench's scenarios, because it depends on what the table holds. This covers whether the first index equals the computed hash, whether the scrambled key compares bit for bit, the wrap from the last slot to slot 0, and the exact probe count and latency for a given table fill.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    localparam int MAC_W   = 48;
    localparam int IDX_W   = 11;
    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 2 * WORD_W;
    localparam int FLAG_W  = 3;

    // flag positions in the low entry word
    localparam int F_VALID = 0;
    localparam int F_SKIP  = 1;
    localparam int F_DEST  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_DONE
    } mhf_state_e;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
    import mhf_pkg::*;
(
    input  logic [MAC_W-1:0] mac,
    output logic [IDX_W-1:0] idx
);
    localparam int NBYTES = MAC_W / 8;

    logic [MAC_W-1:0] rev;

    // reverse bit order inside each byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign rev[b*8+k] = mac[b*8+7-k];
        end
    end

    logic [15:0] hr;
    logic [31:0] lr;
    logic [8:0]  fa, fb, fc;

    assign hr = rev[47:32];
    assign lr = rev[31:0];
    assign fa = {lr[14:8], lr[1:0]};
    assign fb = lr[23:15];
    assign fc = {hr[0], lr[31:24]};
    assign idx = {lr[3:2], fa ^ fb ^ fc};
endmodule

// File: rtl/mhf_key.sv
module mhf_key
    import mhf_pkg::*;
(
    input  logic [MAC_W-1:0]         mac,
    output logic [WORD_W-1:FLAG_W]   key_lo,
    output logic [WORD_W-1:0]        key_hi
);
    logic [15:0] h;
    logic [31:0] l;

    assign h = mac[47:32];
    assign l = mac[31:0];

    assign key_lo = {l[20], l[19:16], l[31:28], l[27:24],
                     h[7:4], h[3:0], h[15:12], h[11:8]};
    assign key_hi = {13'd0, l[7:4], l[3:0], l[15:12], l[11:8], l[23:21]};
endmodule

// File: rtl/mhf_cmp.sv
module mhf_cmp
    import mhf_pkg::*;
(
    input  logic [ENTRY_W-1:0]     entry,
    input  logic [WORD_W-1:FLAG_W] key_lo,
    input  logic [WORD_W-1:0]      key_hi,
    output logic                   ent_valid,
    output logic                   ent_match,
    output logic                   ent_skip,
    output logic                   ent_dest
);
    logic [WORD_W-1:0] lo_w, hi_w;

    assign lo_w      = entry[WORD_W-1:0];
    assign hi_w      = entry[ENTRY_W-1:WORD_W];
    assign ent_valid = lo_w[F_VALID];
    assign ent_skip  = lo_w[F_SKIP];
    assign ent_dest  = lo_w[F_DEST];
    assign ent_match = ent_valid && (lo_w[WORD_W-1:FLAG_W] == key_lo)
                       && (hi_w == key_hi);
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int HOP_LIMIT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr_valid,
    input  logic [47:0]        addr_mac,
    output logic               addr_ready,
    output logic               tbl_rd_en,
    output logic [10:0]        tbl_rd_idx,
    input  logic [63:0]        tbl_rd_data,
    output logic               res_valid,
    output logic               res_accept,
    output logic               res_hit,
    output logic               res_skip,
    output logic               res_dest
);
    localparam int HOP_W = $clog2(HOP_LIMIT + 1);

    mhf_state_e state_q, state_d;

    logic [MAC_W-1:0]        mac_q;
    logic [IDX_W-1:0]        idx_q;
    logic [HOP_W-1:0]        hop_q;
    logic                    acc_q, hit_q, skip_q, dest_q;
    logic [IDX_W-1:0]        hash_idx;
    logic [WORD_W-1:FLAG_W]  key_lo;
    logic [WORD_W-1:0]       key_hi;
    logic                    e_valid, e_match, e_skip, e_dest;
    logic                    take, last_hop, finish;

    mhf_hash u_hash (.mac(addr_mac), .idx(hash_idx));
    mhf_key  u_key  (.mac(mac_q), .key_lo(key_lo), .key_hi(key_hi));
    mhf_cmp  u_cmp  (.entry(tbl_rd_data), .key_lo(key_lo), .key_hi(key_hi),
                     .ent_valid(e_valid), .ent_match(e_match),
                     .ent_skip(e_skip), .ent_dest(e_dest));

    assign take     = (state_q == ST_IDLE) && addr_valid;
    assign last_hop = (hop_q == HOP_W'(HOP_LIMIT - 1));
    assign finish   = !e_valid || e_match || last_hop;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (addr_valid) state_d = ST_READ;
            ST_READ: state_d = ST_WAIT;
            ST_WAIT: state_d = finish ? ST_DONE : ST_READ;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_q  <= '0;
            idx_q  <= '0;
            hop_q  <= '0;
            acc_q  <= 1'b0;
            hit_q  <= 1'b0;
            skip_q <= 1'b0;
            dest_q <= 1'b0;
        end else if (take) begin
            mac_q <= addr_mac;
            idx_q <= hash_idx;
            hop_q <= '0;
        end else if (state_q == ST_WAIT) begin
            if (finish) begin
                hit_q  <= e_match;
                acc_q  <= e_match && !e_skip;
                skip_q <= e_match && e_skip;
                dest_q <= e_match && e_dest;
            end else begin
                idx_q <= idx_q + 1'b1;
                hop_q <= hop_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        addr_ready = (state_q == ST_IDLE);
        tbl_rd_en  = (state_q == ST_READ);
        tbl_rd_idx = idx_q;
        res_valid  = (state_q == ST_DONE);
        res_accept = res_valid && acc_q;
        res_hit    = res_valid && hit_q;
        res_skip   = res_valid && skip_q;
        res_dest   = res_valid && dest_q;
    end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int HOP_LIMIT = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        addr_valid,
    input logic        addr_ready,
    input logic        tbl_rd_en,
    input logic [10:0] tbl_rd_idx,
    input logic        res_valid,
    input logic        res_accept,
    input logic        res_hit,
    input logic        res_skip
);
    localparam int CW = $clog2(HOP_LIMIT + 2);

    logic [CW-1:0] rd_cnt;
    logic [10:0]   prev_idx;
    logic          have_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt    <= '0;
            prev_idx  <= '0;
            have_prev <= 1'b0;
        end else if (addr_valid && addr_ready) begin
            rd_cnt    <= '0;
            have_prev <= 1'b0;
        end else if (tbl_rd_en) begin
            rd_cnt    <= rd_cnt + 1'b1;
            prev_idx  <= tbl_rd_idx;
            have_prev <= 1'b1;
        end
    end

    // R9
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en || res_valid) |-> !addr_ready);
    // R6
    accept_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> (res_hit && !res_skip));
    // R4
    miss_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> !res_accept);
    // R8
    hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> (rd_cnt < CW'(HOP_LIMIT)));
    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd_en && have_prev) |-> (tbl_rd_idx == prev_idx + 11'd1));
    // R10
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |=> !tbl_rd_en);
endmodule

bind mac_hash_filter mhf_checker #(.HOP_LIMIT(HOP_LIMIT)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .tbl_rd_en(tbl_rd_en),
    .tbl_rd_idx(tbl_rd_idx), .res_valid(res_valid),
    .res_accept(res_accept), .res_hit(res_hit), .res_skip(res_skip)
);

// File: tb/mac_hash_filter_tb.sv
module mac_hash_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOPS = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [47:0] addr_mac = '0;
    logic        addr_ready, tbl_rd_en;
    logic [10:0] tbl_rd_idx;
    logic [63:0] tbl_rd_data;
    logic        res_valid, res_accept, res_hit, res_skip, res_dest;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_hash_filter #(.HOP_LIMIT(HOPS)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid),
        .addr_mac(addr_mac), .addr_ready(addr_ready),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
        .tbl_rd_data(tbl_rd_data), .res_valid(res_valid),
        .res_accept(res_accept), .res_hit(res_hit),
        .res_skip(res_skip), .res_dest(res_dest)
    );

    logic [63:0] mem [0:2047];
    always_ff @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_idx];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // results of last lookup
    int          nrd, lat;
    logic [10:0] rd_log [0:31];
    logic        r_acc, r_hit, r_skip, r_dest, r_after, busy_ok;
    bit          got;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rv8(input logic [7:0] x);
        logic [7:0] y;
        for (int i = 0; i < 8; i++) y[i] = x[7-i];
        return y;
    endfunction

    function automatic logic [10:0] href(input logic [47:0] m);
        logic [15:0] h;
        logic [31:0] l;
        h = {rv8(m[47:40]), rv8(m[39:32])};
        l = {rv8(m[31:24]), rv8(m[23:16]), rv8(m[15:8]), rv8(m[7:0])};
        return {l[3:2], {l[14:8], l[1:0]} ^ l[23:15] ^ {h[0], l[31:24]}};
    endfunction

    function automatic logic [63:0] pack(input logic [47:0] m, input logic [2:0] fl);
        logic [15:0] h;
        logic [31:0] l, lo, hi;
        h = m[47:32];
        l = m[31:0];
        lo = {l[20], l[19:16], l[31:28], l[27:24], h[7:4], h[3:0], h[15:12], h[11:8], fl};
        hi = {13'd0, l[7:4], l[3:0], l[15:12], l[11:8], l[23:21]};
        return {hi, lo};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = '0;
    endtask

    task automatic lookup(input logic [47:0] m);
        @(negedge clk);
        addr_mac   = m;
        addr_valid = 1'b1;
        @(negedge clk);
        addr_valid = 1'b0;
        lat = 1; nrd = 0; got = 0; busy_ok = 1;
        while (!got && lat < 200) begin
            if (addr_ready) busy_ok = 0;
            if (tbl_rd_en) begin
                if (nrd < 32) rd_log[nrd] = tbl_rd_idx;
                nrd++;
            end
            if (res_valid) begin
                got = 1;
                r_acc = res_accept; r_hit = res_hit;
                r_skip = res_skip; r_dest = res_dest;
            end else begin
                @(negedge clk);
                lat++;
            end
        end
        chk(got, "R9", "lookup timeout", 0, 1);
        @(negedge clk);
        r_after = res_valid;
    endtask

    logic [63:0] seed = 64'h0123_4567_89ab_cdef;
    function automatic logic [47:0] nextmac();
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        return seed[63:16];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] m, m2;
        logic [10:0] hx;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(addr_ready == 1'b1, "R1", "addr_ready in reset", addr_ready, 1);
        chk(res_valid == 1'b0, "R1", "res_valid in reset", res_valid, 0);
        chk(tbl_rd_en == 1'b0, "R1", "tbl_rd_en in reset", tbl_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(addr_ready == 1'b1, "R1", "addr_ready after reset", addr_ready, 1);

        // R2 / R4 / R9 / R10 sweep on empty table
        for (int t = 0; t < 64; t++) begin
            m = nextmac();
            lookup(m);
            chk(rd_log[0] == href(m), "R2", "first index", rd_log[0], href(m));
            chk(nrd == 1, "R4", "reads on empty slot", nrd, 1);
            chk(!r_hit && !r_acc, "R4", "miss result", {r_hit, r_acc}, 0);
            chk(lat == 3, "R10", "latency one probe", lat, 3);
            chk(!r_after && busy_ok, "R9", "single pulse/busy", {r_after, busy_ok}, 1);
        end

        // R6 match at hashed slot, dest set
        m = 48'h0050_43a1_b2c3;
        clear_mem();
        mem[href(m)] = pack(m, 3'b101);
        lookup(m);
        chk(r_acc && r_hit && r_dest && !r_skip, "R6", "accept dest=1",
            {r_acc, r_hit, r_skip, r_dest}, 4'b1101);
        mem[href(m)] = pack(m, 3'b001);
        lookup(m);
        chk(r_acc && !r_dest, "R6", "accept dest=0", {r_acc, r_dest}, 2'b10);

        // R7 skip set
        mem[href(m)] = pack(m, 3'b011);
        lookup(m);
        chk(!r_acc && r_hit && r_skip, "R7", "skip reject",
            {r_acc, r_hit, r_skip}, 3'b011);

        // R3 / R10 match three slots later
        clear_mem();
        m2 = m ^ 48'h1;
        hx = href(m);
        for (int i = 0; i < 3; i++) mem[11'(hx + 11'(i))] = pack(m2, 3'b001);
        mem[11'(hx + 11'd3)] = pack(m, 3'b001);
        lookup(m);
        chk(nrd == 4 && r_acc, "R3", "match at hop 4", nrd, 4);
        for (int i = 0; i < 4; i++)
            chk(rd_log[i] == 11'(hx + 11'(i)), "R3", "probe step", rd_log[i], 11'(hx + 11'(i)));
        chk(lat == 9, "R10", "latency four probes", lat, 9);

        // R3 wrap 2047 -> 0
        m = 48'h0a0b_0000_0000;
        for (int i = 0; i < (1 << 20); i++) begin
            m[31:0] = 32'(i) * 32'h9e37_79b9;
            if (href(m) == 11'd2047) break;
        end
        chk(href(m) == 11'd2047, "R3", "wrap address found", href(m), 2047);
        clear_mem();
        mem[2047] = pack(m ^ 48'h10, 3'b001);
        mem[0]    = pack(m, 3'b001);
        lookup(m);
        chk(nrd == 2 && rd_log[1] == 11'd0 && r_acc, "R3", "wrap to slot 0",
            rd_log[1], 0);

        // R8 hop exhaustion and boundary
        m = 48'h1122_3344_5566;
        hx = href(m);
        clear_mem();
        for (int i = 0; i < 16; i++) mem[11'(hx + 11'(i))] = pack(m ^ 48'h800, 3'b001);
        mem[11'(hx + 11'd12)] = pack(m, 3'b001);
        lookup(m);
        chk(nrd == HOPS, "R8", "reads when exhausted", nrd, HOPS);
        chk(!r_hit && !r_acc, "R8", "exhausted reject", {r_hit, r_acc}, 0);
        chk(lat == 2 * HOPS + 1, "R10", "latency exhausted", lat, 2 * HOPS + 1);
        mem[11'(hx + 11'd11)] = pack(m, 3'b001);
        lookup(m);
        chk(nrd == HOPS && r_acc && r_hit, "R8", "match at last hop", {nrd, r_acc}, {HOPS, 1'b1});

        // R5 single-bit near misses over all 61 compared bits
        m = 48'hfedc_ba98_7654;
        hx = href(m);
        for (int b = 0; b < 61; b++) begin
            clear_mem();
            mem[hx] = pack(m, 3'b001) ^ (64'h1 << (b + 3));
            lookup(m);
            chk(!r_hit && nrd == 2, "R5", "flipped bit rejects", {r_hit, nrd}, 2);
        end
        // R5 flags do not take part in comparison
        clear_mem();
        mem[hx] = pack(m, 3'b111);
        lookup(m);
        chk(r_hit && r_skip && r_dest, "R5", "flags ignored in compare",
            {r_hit, r_skip, r_dest}, 3'b111);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule